// File: doc/BRIEF.md
# Deferred Invalidation Queue with Fence Stall

This block sits beside a core's small local cache tag/valid array. Other agents send invalidation requests for individual lines. The block acknowledges each request in the cycle it arrives and stores the line index in an in-order queue. It clears the matching valid bit later, and only in cycles when no load is reading the valid array. Until that happens, a load to the line still hits and returns whatever the core has cached locally. The requester therefore never waits for the local array.

The core's load issue logic uses two outputs: a queue-empty flag and a fence stall. A load fence holds later loads back until every queued invalidation has reached the valid array. A full fence does the same and also waits until the store side reports that its buffer is empty. A three-state machine controls the stall:

- `FN_IDLE`: no stall.
- `FN_LOAD`: waiting for the queue to empty.
- `FN_FULL`: waiting for the queue to empty and for the store buffer to be empty.

The transitions are:

- IDLE to LOAD on a load fence.
- IDLE to FULL on a full fence.
- LOAD to FULL on a full fence.
- LOAD to IDLE when the queue is empty and no new fence is raised.
- FULL to IDLE when the queue and the store buffer are both empty and no new fence is raised.

Fills set valid bits through a separate port.

Top module: `inval_queue_fence`

## Requirements
- R1: After reset the queue is empty (`q_empty`=1), `fence_stall`=0, `inv_ready`=1, and every line looks up as a miss.
- R2: A fill of line L makes a lookup of L hit from the next cycle onwards. `lookup_hit` is combinational on `lookup_valid` and `lookup_line`.
- R3: When `inv_valid` is high and the queue is not full, `inv_ack` is high in that same cycle, and the line is recorded in the queue at the next clock edge.
- R4: While a recorded invalidation of line L has not yet been applied, a lookup of L that previously hit keeps hitting.
- R5: Queued invalidations are applied one per clock edge, in arrival order, and only on edges where `lookup_valid` is low.
- R6: With DEPTH entries queued, `inv_ready` and `inv_ack` stay low whatever `inv_valid` does. The request is taken in the first cycle after an entry has drained.
- R7: If an applied invalidation and a fill name the same line at the same edge, the line ends invalid.
- R8: A load fence raises `fence_stall` from the next cycle. With N entries queued and no new invalidations, the stall lasts max(N,1) cycles. It falls only after the queue is empty, and every queued line then misses.
- R9: A full fence keeps `fence_stall` high while `sb_empty` is low, even when the queue is empty. It falls one cycle after `sb_empty` is seen high with the queue empty.
- R10: `q_empty` is high exactly when no invalidation is pending in the queue.
- R11: A full fence raised while a load fence is pending upgrades the wait, so the stall then also requires `sb_empty`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| inv_valid | input | 1 | Incoming invalidation request |
| inv_line | input | IDX_W | Line index to invalidate |
| inv_ready | output | 1 | Queue has a free entry |
| inv_ack | output | 1 | Request accepted and acknowledged this cycle |
| fill_valid | input | 1 | Fill marks a line valid |
| fill_line | input | IDX_W | Line index being filled |
| lookup_valid | input | 1 | A load reads the valid array this cycle |
| lookup_line | input | IDX_W | Line index being looked up |
| lookup_hit | output | 1 | Looked-up line is currently valid |
| load_fence | input | 1 | Load fence request pulse |
| full_fence | input | 1 | Full fence request pulse |
| sb_empty | input | 1 | Store buffer reports empty |
| q_empty | output | 1 | No invalidations pending |
| fence_stall | output | 1 | Later loads (and stores for a full fence) must wait |

## Verification
The assertions assume that the core issues no lookup while `fence_stall` is high. If lookups continued during the stall, the queue could never drain and the stall would never end. They also assume that a requester holds `inv_valid` until it sees `inv_ack`, and that `sb_empty` comes from a store buffer outside this block. The stimulus drops `lookup_valid` in every cycle where a stall is expected or a drain is wanted. It holds `lookup_valid` high only to freeze the queue, which is how it builds up a backlog and fills the queue.

// File: rtl/fenceq_pkg.sv
package fenceq_pkg;
    typedef enum logic [1:0] {
        FN_IDLE = 2'd0,
        FN_LOAD = 2'd1,
        FN_FULL = 2'd2
    } fence_state_e;
endpackage

// File: rtl/invq_fifo.sv
module invq_fifo #(
    parameter int IDX_W = 4,
    parameter int DEPTH = 4
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             push,
    input  logic [IDX_W-1:0] push_idx,
    input  logic             pop,
    output logic [IDX_W-1:0] head_idx,
    output logic             full,
    output logic             empty
);
    localparam int PTR_W = (DEPTH > 1) ? $clog2(DEPTH) : 1;
    localparam int CNT_W = $clog2(DEPTH + 1);

    logic [IDX_W-1:0] mem [DEPTH];
    logic [PTR_W-1:0] wr_ptr, rd_ptr;
    logic [CNT_W-1:0] count;

    function automatic logic [PTR_W-1:0] bump(input logic [PTR_W-1:0] p);
        return (p == PTR_W'(DEPTH - 1)) ? '0 : p + 1'b1;
    endfunction

    always_ff @(posedge clk) begin
        if (push) begin
            mem[wr_ptr] <= push_idx;
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            wr_ptr <= '0;
            rd_ptr <= '0;
            count  <= '0;
        end else begin
            if (push) wr_ptr <= bump(wr_ptr);
            if (pop)  rd_ptr <= bump(rd_ptr);
            unique case ({push, pop})
                2'b10:   count <= count + 1'b1;
                2'b01:   count <= count - 1'b1;
                default: count <= count;
            endcase
        end
    end

    assign head_idx = mem[rd_ptr];
    assign full     = (count == CNT_W'(DEPTH));
    assign empty    = (count == '0);

    // R6: the queue can only become full through an accepted request
    p_full_by_push_r6: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(full) |-> $past(push));

    // R5: a drain never takes from an empty queue
    p_no_underflow_r5: assert property (@(posedge clk) disable iff (!rst_n)
        pop |-> !empty);
endmodule

// File: rtl/line_valid_array.sv
module line_valid_array #(
    parameter int LINES = 16,
    parameter int IDX_W = $clog2(LINES)
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             set_en,
    input  logic [IDX_W-1:0] set_idx,
    input  logic             clr_en,
    input  logic [IDX_W-1:0] clr_idx,
    input  logic [IDX_W-1:0] rd_idx,
    output logic             rd_hit
);
    logic [LINES-1:0] valid;

    for (genvar g = 0; g < LINES; g++) begin : g_line
        localparam logic [IDX_W-1:0] MY_IDX = IDX_W'(g);
        always_ff @(posedge clk) begin
            if (!rst_n) begin
                valid[g] <= 1'b0;
            end else if (clr_en && clr_idx == MY_IDX) begin
                valid[g] <= 1'b0;   // invalidation beats a same-edge fill
            end else if (set_en && set_idx == MY_IDX) begin
                valid[g] <= 1'b1;
            end
        end
    end

    assign rd_hit = valid[rd_idx];

    // R7: same-line collision of drain and fill leaves the line invalid
    p_inv_wins_r7: assert property (@(posedge clk) disable iff (!rst_n)
        (clr_en && set_en && clr_idx == set_idx) |=> !valid[$past(clr_idx)]);
endmodule

// File: rtl/fence_fsm.sv
module fence_fsm
    import fenceq_pkg::*;
(
    input  logic clk,
    input  logic rst_n,
    input  logic ld_req,
    input  logic full_req,
    input  logic q_empty,
    input  logic sb_empty,
    output logic stall
);
    fence_state_e state, state_nx;

    always_ff @(posedge clk) begin
        if (!rst_n) state <= FN_IDLE;
        else        state <= state_nx;
    end

    always_comb begin
        state_nx = state;
        unique case (state)
            FN_IDLE: begin
                if (full_req)    state_nx = FN_FULL;
                else if (ld_req) state_nx = FN_LOAD;
            end
            FN_LOAD: begin
                if (full_req)                 state_nx = FN_FULL;
                else if (q_empty && !ld_req)  state_nx = FN_IDLE;
            end
            FN_FULL: begin
                if (q_empty && sb_empty && !ld_req && !full_req)
                    state_nx = FN_IDLE;
            end
            default: state_nx = FN_IDLE;
        endcase
    end

    always_comb begin
        stall = (state != FN_IDLE);
    end

    // R8: any fence request stalls in the following cycle
    p_fence_stalls_r8: assert property (@(posedge clk) disable iff (!rst_n)
        (ld_req || full_req) |=> stall);

    // R8: the stall only ends once the queue was seen empty
    p_release_empty_r8: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(stall) |-> $past(q_empty));

    // R9: leaving a full-fence wait needs the store buffer empty
    p_full_needs_sb_r9: assert property (@(posedge clk) disable iff (!rst_n)
        ($past(state) == FN_FULL && state == FN_IDLE) |-> $past(sb_empty));
endmodule

// File: rtl/inval_queue_fence.sv
module inval_queue_fence #(
    parameter int LINES = 16,
    parameter int DEPTH = 4,
    localparam int IDX_W = $clog2(LINES)
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             inv_valid,
    input  logic [IDX_W-1:0] inv_line,
    output logic             inv_ready,
    output logic             inv_ack,
    input  logic             fill_valid,
    input  logic [IDX_W-1:0] fill_line,
    input  logic             lookup_valid,
    input  logic [IDX_W-1:0] lookup_line,
    output logic             lookup_hit,
    input  logic             load_fence,
    input  logic             full_fence,
    input  logic             sb_empty,
    output logic             q_empty,
    output logic             fence_stall
);
    logic             q_full, q_is_empty, push, pop, rd_hit;
    logic [IDX_W-1:0] head_idx;

    // acknowledge is given as soon as the entry is taken; no wait on the array
    assign push      = inv_valid && !q_full;
    assign inv_ready = !q_full;
    assign inv_ack   = push;
    // loads own the array port; draining uses only idle cycles
    assign pop       = !q_is_empty && !lookup_valid;

    invq_fifo #(.IDX_W(IDX_W), .DEPTH(DEPTH)) u_fifo (
        .clk      (clk),
        .rst_n    (rst_n),
        .push     (push),
        .push_idx (inv_line),
        .pop      (pop),
        .head_idx (head_idx),
        .full     (q_full),
        .empty    (q_is_empty)
    );

    line_valid_array #(.LINES(LINES), .IDX_W(IDX_W)) u_valid (
        .clk     (clk),
        .rst_n   (rst_n),
        .set_en  (fill_valid),
        .set_idx (fill_line),
        .clr_en  (pop),
        .clr_idx (head_idx),
        .rd_idx  (lookup_line),
        .rd_hit  (rd_hit)
    );

    fence_fsm u_fence (
        .clk      (clk),
        .rst_n    (rst_n),
        .ld_req   (load_fence),
        .full_req (full_fence),
        .q_empty  (q_is_empty),
        .sb_empty (sb_empty),
        .stall    (fence_stall)
    );

    assign lookup_hit = lookup_valid && rd_hit;
    assign q_empty    = q_is_empty;

    // R3/R10: an acknowledged request is pending in the next cycle
    p_ack_records_r3: assert property (@(posedge clk) disable iff (!rst_n)
        inv_ack |=> !q_empty);

    // R5: a load in progress freezes the backlog
    p_load_blocks_drain_r5: assert property (@(posedge clk) disable iff (!rst_n)
        (lookup_valid && !q_empty) |=> !q_empty);

    // R8: input assumption, the core issues no load while stalled
    p_no_load_in_stall_r8: assert property (@(posedge clk) disable iff (!rst_n)
        fence_stall |-> !lookup_valid);
endmodule

// File: tb/tb_inval_queue_fence.sv
module tb_inval_queue_fence;
    localparam int LINES = 16;
    localparam int DEPTH = 4;
    localparam int IW    = $clog2(LINES);

    logic clk = 1'b0;
    logic rst_n;
    logic inv_valid, fill_valid, lookup_valid, load_fence, full_fence, sb_empty;
    logic [IW-1:0] inv_line, fill_line, lookup_line;
    logic inv_ready, inv_ack, lookup_hit, q_empty, fence_stall;

    int n_cmp = 0;
    int n_bad = 0;
    bit done  = 1'b0;

    always #10 clk = ~clk;

    inval_queue_fence #(.LINES(LINES), .DEPTH(DEPTH)) dut (
        .clk(clk), .rst_n(rst_n),
        .inv_valid(inv_valid), .inv_line(inv_line),
        .inv_ready(inv_ready), .inv_ack(inv_ack),
        .fill_valid(fill_valid), .fill_line(fill_line),
        .lookup_valid(lookup_valid), .lookup_line(lookup_line),
        .lookup_hit(lookup_hit),
        .load_fence(load_fence), .full_fence(full_fence),
        .sb_empty(sb_empty), .q_empty(q_empty), .fence_stall(fence_stall)
    );

    // vector: [5:2] line, [1] 1=lookup 0=fill, [0] expected hit
    localparam logic [5:0] VECS [8] = '{
        {4'd3,  1'b0, 1'b0},
        {4'd7,  1'b0, 1'b0},
        {4'd3,  1'b1, 1'b1},
        {4'd7,  1'b1, 1'b1},
        {4'd5,  1'b1, 1'b0},
        {4'd15, 1'b0, 1'b0},
        {4'd15, 1'b1, 1'b1},
        {4'd0,  1'b1, 1'b0}
    };

    task automatic chk(input string req, input int act, input int exp_v);
        n_cmp++;
        if (act != exp_v) begin
            n_bad++;
            $display("FAIL %s: got %0d expected %0d", req, act, exp_v);
        end
    endtask

    // start a new cycle at the falling edge with every strobe cleared
    task automatic cyc();
        @(negedge clk);
        inv_valid = 0; fill_valid = 0; lookup_valid = 0;
        load_fence = 0; full_fence = 0;
    endtask

    task automatic do_fill(input int ln);
        cyc(); fill_valid = 1; fill_line = IW'(ln);
    endtask

    task automatic look(input int ln, input int exp_v, input string req);
        cyc(); lookup_valid = 1; lookup_line = IW'(ln); #1;
        chk(req, lookup_hit, exp_v);
    endtask

    // queue an invalidation while a load holds the array (no drain)
    task automatic inv_held(input int ln);
        cyc(); inv_valid = 1; inv_line = IW'(ln);
        lookup_valid = 1; lookup_line = '0;
    endtask

    initial begin
        repeat (100000) @(posedge clk);
        if (!done) begin
            n_bad++; n_cmp++;
            $display("FAIL watchdog: got 0 expected 1 (run finished)");
            $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
            $finish;
        end
    end

    initial begin
        rst_n = 0; sb_empty = 1;
        inv_valid = 0; fill_valid = 0; lookup_valid = 0;
        load_fence = 0; full_fence = 0;
        inv_line = '0; fill_line = '0; lookup_line = '0;
        repeat (3) @(posedge clk);
        @(negedge clk); rst_n = 1;

        // R1 reset state
        cyc(); #1;
        chk("R1 q_empty", q_empty, 1);
        chk("R1 stall", fence_stall, 0);
        chk("R1 ready", inv_ready, 1);
        look(3, 0, "R1 miss 3");
        look(12, 0, "R1 miss 12");

        // R2 vector walk
        for (int i = 0; i < 8; i++) begin
            if (VECS[i][1]) look(int'(VECS[i][5:2]), int'(VECS[i][0]), "R2 vector lookup");
            else            do_fill(int'(VECS[i][5:2]));
        end

        // R3 immediate ack, R4 stale hit, R10 q_empty
        cyc(); inv_valid = 1; inv_line = 4'd3;
        lookup_valid = 1; lookup_line = 4'd3; #1;
        chk("R3 ack same cycle", inv_ack, 1);
        chk("R4 hit before record", lookup_hit, 1);
        look(3, 1, "R4 stale hit");
        chk("R10 q_empty low", q_empty, 0);
        look(3, 1, "R4 stale hit held");
        cyc();                               // idle: drain
        look(3, 0, "R5 applied after idle");
        chk("R10 q_empty high", q_empty, 1);

        // R5 arrival order
        do_fill(3); do_fill(7); do_fill(15);
        inv_held(7); inv_held(3); inv_held(15);
        cyc();                               // drain 7
        look(7, 0, "R5 first applied");
        look(3, 1, "R5 second pending");
        look(15, 1, "R5 third pending");
        cyc();                               // drain 3
        look(3, 0, "R5 second applied");
        look(15, 1, "R5 third still pending");
        cyc();                               // drain 15
        look(15, 0, "R5 third applied");
        chk("R10 empty after drain", q_empty, 1);

        // R6 full queue back-pressure
        do_fill(1); do_fill(2); do_fill(4); do_fill(5); do_fill(6);
        inv_held(1); inv_held(2); inv_held(4); inv_held(5);
        inv_held(6); #1;
        chk("R6 ready low when full", inv_ready, 0);
        chk("R6 ack withheld", inv_ack, 0);
        cyc(); inv_valid = 1; inv_line = 4'd6; #1;   // drain one at this edge
        chk("R6 still full this cycle", inv_ready, 0);
        chk("R6 ack still withheld", inv_ack, 0);
        inv_held(6); #1;
        chk("R6 ready after drain", inv_ready, 1);
        chk("R6 ack after drain", inv_ack, 1);
        look(6, 1, "R4 stale hit on line 6");
        repeat (5) cyc();
        chk("R6 queue drained", q_empty, 1);
        look(6, 0, "R6 late request applied");
        look(1, 0, "R6 first entry applied");

        // R7 invalidation beats same-edge fill
        do_fill(9);
        cyc(); inv_valid = 1; inv_line = 4'd9;
        cyc(); fill_valid = 1; fill_line = 4'd9;    // drain 9 and fill 9 together
        look(9, 0, "R7 invalidation wins");
        do_fill(9);
        look(9, 1, "R7 fill alone sets");

        // R8 load fence with three queued entries
        do_fill(10); do_fill(11); do_fill(12);
        inv_held(10); inv_held(11); inv_held(12);
        cyc(); load_fence = 1; #1;
        chk("R8 no stall in request cycle", fence_stall, 0);
        for (int k = 0; k < 3; k++) begin
            cyc(); #1;
            chk("R8 stall while draining", fence_stall, 1);
        end
        cyc(); #1;
        chk("R8 stall released", fence_stall, 0);
        chk("R8 queue empty at release", q_empty, 1);
        look(10, 0, "R8 line 10 applied");
        look(12, 0, "R8 line 12 applied");

        // R8 load fence on empty queue: one cycle
        cyc(); load_fence = 1;
        cyc(); #1; chk("R8 empty-queue stall", fence_stall, 1);
        cyc(); #1; chk("R8 empty-queue release", fence_stall, 0);

        // R9 full fence waits for store buffer
        cyc(); full_fence = 1; sb_empty = 0;
        for (int k = 0; k < 4; k++) begin
            cyc(); #1;
            chk("R9 stall on busy store buffer", fence_stall, 1);
        end
        cyc(); sb_empty = 1; #1;
        chk("R9 stall until edge", fence_stall, 1);
        cyc(); #1;
        chk("R9 release after sb_empty", fence_stall, 0);

        // R11 upgrade of a pending load fence
        do_fill(13); do_fill(14);
        inv_held(13); inv_held(14);
        cyc(); load_fence = 1; sb_empty = 0;
        cyc(); full_fence = 1;
        for (int k = 0; k < 3; k++) begin
            cyc(); #1;
            chk("R11 upgraded stall holds", fence_stall, 1);
        end
        chk("R11 queue already empty", q_empty, 1);
        cyc(); sb_empty = 1;
        cyc(); #1;
        chk("R11 release after sb_empty", fence_stall, 0);
        look(14, 0, "R11 line 14 applied");

        done = 1'b1;
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
        $finish;
    end
endmodule